// File: doc/BRIEF.md
# Dual 8-bit Parallel Port with Bit Set/Clear Aliases

This block gives a processor two independent 8-bit general-purpose ports, A and B, reached over an asynchronous strobe-and-acknowledge bus. Each port has a direction register, an output register, a synchronized input path and two write-only-effect aliases. Writing ones to the set alias raises the matching output bits. Writing ones to the clear alias lowers them. Single bits can therefore change without a read-modify-write sequence.

The bus side samples chip select and data strobe through a synchronizer. It performs exactly one register access per strobe and answers with an active-low acknowledge, which it holds until the strobe is withdrawn. No bus-phase clock or valid-address qualifier is used.

Each port also has an edge-sensitive event input. A rising edge latches a flag. When that port's enable bit is set, the flag drives a shared active-low interrupt request, intended to be wired to a fixed priority level 2 that is acknowledged by autovector. Reading the port's data register clears its flag.

Top module: `gpio_pair_bus`

## Requirements
- R1: While reset is held and after its release, both ports' direction and output values are zero, the acknowledge is high (released), the interrupt request is high and the read bus is zero.
- R2: Address bit 2 selects the port (0 = A, 1 = B), and address bits 1:0 select the register: 0 direction, 1 data, 2 set alias, 3 clear alias. The output enable pins equal the direction register (1 = drive), and the output pins equal the data register.
- R3: A write to the set alias ORs its low byte into the data register.
- R4: A write to the clear alias clears every data register bit where its low byte has a one.
- R5: Reading the data address returns, in bits 7:0, the data register bit for each output pin and the synchronized pin value for each input pin.
- R6: Reading a set or clear alias returns the synchronized pin values for all eight pins in bits 7:0. On every read of a port, bit 15 shows that port's event flag and bit 8 shows its enable.
- R7: Reading the direction address returns the direction register in bits 7:0.
- R8: The acknowledge falls on the third rising clock edge after chip select and strobe both go low, and it rises on the third rising edge after the strobe is withdrawn. Each strobe performs one access.
- R9: Pin inputs pass through a two-stage synchronizer. Read data stays constant while the acknowledge is low, even if the pins change.
- R10: A rising edge on a port's event input sets that port's flag. The interrupt request is low exactly when some port has both its flag and its enable set.
- R11: Only a read of a port's data address clears its flag. If a new edge is detected in the same cycle as that read, the flag stays set.
- R12: A strobe with chip select high is ignored: no acknowledge is given and no register changes.
- R13: A write to the direction address also loads the enable bit from data bit 8. Writes to the data, set and clear addresses ignore bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, held from the access until the next read |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| evt_a | input | 1 | Port A event input, rising-edge sensitive |
| evt_b | input | 1 | Port B event input, rising-edge sensitive |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach from the ports is a new event edge arriving in the very cycle that a data read clears the flag. The stimulus raises the event input on the same clock phase that starts the read strobe. Both paths have the same synchronizer depth, so the edge is detected exactly at the access cycle, and the flag must survive with the interrupt still asserted. The held read data is tested by changing the pins while the acknowledge is low. The ignored strobe is tested by keeping the strobe low for several cycles with chip select high and then reading the registers back.

// File: rtl/gpio_pair_pkg.sv
// Shared types and constants for the dual parallel port.
// Assumes a 16-bit bus with 8-bit ports; the status bits sit above the port byte.
package gpio_pair_pkg;
    localparam int BUS_W  = 16;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 3;
    localparam int EN_BIT   = PORT_W;     // enable bit position in a read or direction write
    localparam int FLAG_BIT = BUS_W - 1;  // flag bit position in a read

    typedef enum logic [1:0] {
        SEL_DIR  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_SET  = 2'd2,
        SEL_CLR  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherency guaranteed across bits).
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s > 0) ? s - 1 : 0];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_bus_ack.sv
// Bus handshake: synchronizes the qualified strobe, issues one access pulse
// per strobe and drives the acknowledge until the strobe goes away.
// Assumes address, direction and write data are stable while the strobe is low.
module gpio_bus_ack #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic ds_n,
    output logic commit,
    output logic dtack_n
);
    logic strobe_raw;
    logic strobe_s;
    logic ack_q;

    assign strobe_raw = ~cs_n & ~ds_n;

    gpio_sync #(.W(1), .STAGES(SYNC_STAGES)) u_strobe_sync (
        .clk(clk), .rst_n(rst_n), .d(strobe_raw), .q(strobe_s)
    );

    // Follow the synchronized strobe one cycle later to form the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= strobe_s;
    end

    assign commit  = strobe_s & ~ack_q;
    assign dtack_n = ~ack_q;
endmodule

// File: rtl/gpio_port_unit.sv
// One 8-bit port: direction, output register, set/clear aliases,
// synchronized pins, edge-detected event flag with enable, and read mux.
// Assumes commit is a one-cycle pulse and hit selects this port.
module gpio_port_unit
    import gpio_pair_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              hit,
    input  logic              is_read,
    input  reg_sel_e          sel,
    input  logic [PORT_W-1:0] wr_byte,
    input  logic              wr_en_bit,
    input  logic [PORT_W-1:0] pin_in,
    input  logic              evt_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [BUS_W-1:0]  rd_word,
    output logic              irq
);
    logic [PORT_W-1:0] dir_q, out_q, pin_s;
    logic              en_q, flag_q, evt_s, evt_prev, rise;
    logic              do_wr, do_clr;
    logic [PORT_W-1:0] low_byte;

    gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
    );
    gpio_sync #(.W(1), .STAGES(SYNC_STAGES)) u_evt_sync (
        .clk(clk), .rst_n(rst_n), .d(evt_in), .q(evt_s)
    );

    assign rise   = evt_s & ~evt_prev;
    assign do_wr  = commit & hit & ~is_read;
    assign do_clr = commit & hit & is_read & (sel == SEL_DATA);

    // Remember the previous synchronized event level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_prev <= 1'b0;
        else        evt_prev <= evt_s;
    end

    // Apply register writes selected by the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
            en_q  <= 1'b0;
        end else if (do_wr) begin
            unique case (sel)
                SEL_DIR:  begin dir_q <= wr_byte; en_q <= wr_en_bit; end
                SEL_DATA: out_q <= wr_byte;
                SEL_SET:  out_q <= out_q | wr_byte;
                SEL_CLR:  out_q <= out_q & ~wr_byte;
            endcase
        end
    end

    // Latch event edges; a data read clears unless a new edge arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= rise | (flag_q & ~do_clr);
    end

    // Select the low byte returned for the addressed register.
    always_comb begin
        unique case (sel)
            SEL_DIR:  low_byte = dir_q;
            SEL_DATA: low_byte = (out_q & dir_q) | (pin_s & ~dir_q);
            default:  low_byte = pin_s;
        endcase
    end

    // Assemble the full read word with status bits.
    always_comb begin
        rd_word                = '0;
        rd_word[PORT_W-1:0]    = low_byte;
        rd_word[EN_BIT]        = en_q;
        rd_word[FLAG_BIT]      = flag_q;
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = flag_q & en_q;
endmodule

// File: rtl/gpio_pair_bus.sv
// Top of the dual parallel port: bus handshake, two port units and the
// held read-data register. Assumes a synchronous active-low reset.
module gpio_pair_bus
    import gpio_pair_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              dtack_n,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe,
    input  logic              evt_a,
    input  logic              evt_b,
    output logic              irq_n
);
    localparam int NPORT = 2;

    logic              commit;
    reg_sel_e          sel;
    logic [BUS_W-1:0]  rd_word [NPORT];
    logic [NPORT-1:0]  irq_vec;
    logic [PORT_W-1:0] pin_in_v  [NPORT];
    logic [PORT_W-1:0] pin_out_v [NPORT];
    logic [PORT_W-1:0] pin_oe_v  [NPORT];
    logic [NPORT-1:0]  evt_v;
    logic              unused_hi;

    assign sel       = reg_sel_e'(addr[1:0]);
    assign pin_in_v[0] = pa_in;
    assign pin_in_v[1] = pb_in;
    assign evt_v     = {evt_b, evt_a};
    assign unused_hi = ^{wdata[BUS_W-1:EN_BIT+1]};

    gpio_bus_ack #(.SYNC_STAGES(SYNC_STAGES)) u_ack (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds_n(ds_n),
        .commit(commit), .dtack_n(dtack_n)
    );

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            gpio_port_unit #(.SYNC_STAGES(SYNC_STAGES)) u_port (
                .clk(clk), .rst_n(rst_n), .commit(commit),
                .hit(addr[2] == p[0]), .is_read(rw), .sel(sel),
                .wr_byte(wdata[PORT_W-1:0]), .wr_en_bit(wdata[EN_BIT]),
                .pin_in(pin_in_v[p]), .evt_in(evt_v[p]),
                .pin_out(pin_out_v[p]), .pin_oe(pin_oe_v[p]),
                .rd_word(rd_word[p]), .irq(irq_vec[p])
            );
        end
    endgenerate

    // Capture the addressed read word at the access cycle and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)            rdata <= '0;
        else if (commit && rw) rdata <= addr[2] ? rd_word[1] : rd_word[0];
    end

    assign pa_out = pin_out_v[0];
    assign pa_oe  = pin_oe_v[0];
    assign pb_out = pin_out_v[1];
    assign pb_oe  = pin_oe_v[1];
    assign irq_n  = ~|irq_vec;
endmodule

// File: rtl/gpio_pair_bus_chk.sv
// Timing properties of the dual parallel port, bound to the top module.
module gpio_pair_bus_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        dtack_n,
    input logic [15:0] rdata,
    input logic [7:0]  pa_oe,
    input logic [7:0]  pa_out,
    input logic [7:0]  pb_out,
    input logic        evt_a,
    input logic        evt_b,
    input logic        irq_n
);
    p_no_ack_without_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3)) |-> dtack_n)
        else $error("ack given without chip select");

    p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && $past(!dtack_n)) |-> $stable(rdata))
        else $error("read data moved during acknowledge");

    p_dir_at_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pa_oe) |-> $fell(dtack_n))
        else $error("direction changed outside an access");

    p_out_at_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pa_out) || !$stable(pb_out)) |-> $fell(dtack_n))
        else $error("output changed outside an access");

    p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(evt_a, 2) || $past(evt_b, 2) || $fell(dtack_n)))
        else $error("interrupt without edge or enable write");

    p_irq_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> $fell(dtack_n))
        else $error("interrupt released outside an access");
endmodule

bind gpio_pair_bus gpio_pair_bus_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dtack_n(dtack_n), .rdata(rdata),
    .pa_oe(pa_oe), .pa_out(pa_out), .pb_out(pb_out),
    .evt_a(evt_a), .evt_b(evt_b), .irq_n(irq_n)
);

// File: tb/gpio_pair_bus_bench.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module gpio_pair_bus_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        dtack_n;
    logic [7:0]  pa_in = '0, pb_in = '0;
    logic [7:0]  pa_out, pa_oe, pb_out, pb_oe;
    logic        evt_a = 1'b0, evt_b = 1'b0;
    logic        irq_n;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_pair_bus u_gpio_pair_bus (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds_n(ds_n), .rw(rw), .addr(addr),
        .wdata(wdata), .rdata(rdata), .dtack_n(dtack_n),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .evt_a(evt_a), .evt_b(evt_b), .irq_n(irq_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [7:0] m_dir [2], m_out [2], p1 [2], p2 [2];
    bit m_en [2], m_flag [2], c1 [2], c2 [2], c3 [2];
    bit a1, a2, dk;
    logic [15:0] m_rd;

    function automatic logic [15:0] mword(int i, logic [1:0] s);
        logic [7:0] lo;
        case (s)
            2'd0: lo = m_dir[i];
            2'd1: lo = (m_out[i] & m_dir[i]) | (p2[i] & ~m_dir[i]);
            default: lo = p2[i];
        endcase
        return {m_flag[i], 6'd0, m_en[i], lo};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_dir[i] = '0; m_out[i] = '0; p1[i] = '0; p2[i] = '0;
                m_en[i] = 0; m_flag[i] = 0; c1[i] = 0; c2[i] = 0; c3[i] = 0;
            end
            a1 = 0; a2 = 0; dk = 0; m_rd = '0;
        end else begin
            bit commit, rise, hit, clr;
            commit = a2 && !dk;
            for (int i = 0; i < 2; i++) begin
                rise = c2[i] && !c3[i];
                hit  = commit && (int'(addr[2]) == i);
                clr  = hit && rw && (addr[1:0] == 2'd1);
                if (hit && rw) m_rd = mword(i, addr[1:0]);
                if (hit && !rw) begin
                    case (addr[1:0])
                        2'd0: begin m_dir[i] = wdata[7:0]; m_en[i] = wdata[8]; end
                        2'd1: m_out[i] = wdata[7:0];
                        2'd2: m_out[i] = m_out[i] | wdata[7:0];
                        default: m_out[i] = m_out[i] & ~wdata[7:0];
                    endcase
                end
                m_flag[i] = rise || (m_flag[i] && !clr);
            end
            c3[0] = c2[0]; c2[0] = c1[0]; c1[0] = evt_a;
            c3[1] = c2[1]; c2[1] = c1[1]; c1[1] = evt_b;
            p2[0] = p1[0]; p1[0] = pa_in; p2[1] = p1[1]; p1[1] = pb_in;
            dk = a2; a2 = a1; a1 = !cs_n && !ds_n;
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            chk(dtack_n == !dk, "R8 model dtack", dtack_n, !dk);
            chk(pa_oe == m_dir[0] && pb_oe == m_dir[1], "R2 model oe", {pa_oe, pb_oe}, {m_dir[0], m_dir[1]});
            chk(pa_out == m_out[0] && pb_out == m_out[1], "R3 model out", {pa_out, pb_out}, {m_out[0], m_out[1]});
            chk(rdata == m_rd, "R5 model rdata", rdata, m_rd);
            chk(irq_n == !((m_flag[0] && m_en[0]) || (m_flag[1] && m_en[1])), "R10 model irq",
                irq_n, !((m_flag[0] && m_en[0]) || (m_flag[1] && m_en[1])));
        end
    end

    // Watchdog: counts as a failure and still reports.
    initial begin
        wait (cyc > 100000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected <100000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wait_ack(input logic lvl, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (dtack_n != lvl && n < 50);
    endtask

    task automatic bus_access(input logic r, input logic [2:0] a, input logic [15:0] d, output logic [15:0] q);
        int n;
        @(negedge clk);
        rw = r; addr = a; wdata = d; cs_n = 0; ds_n = 0;
        wait_ack(1'b0, n);
        q = rdata;
        ds_n = 1; cs_n = 1;
        wait_ack(1'b1, n);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        logic [15:0] q;
        bus_access(1'b0, a, d, q);
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] q);
        bus_access(1'b1, a, 16'h0, q);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- directed tests ----------------
    initial begin
        logic [15:0] q;
        int n;
        idle(3);
        chk(pa_oe == 0 && pa_out == 0 && pb_oe == 0 && pb_out == 0, "R1 outputs in reset", {pa_oe, pa_out, pb_oe, pb_out}, 0);
        chk(dtack_n == 1 && irq_n == 1 && rdata == 0, "R1 bus in reset", {dtack_n, irq_n, rdata}, {2'b11, 16'h0});
        rst_n = 1;
        idle(2);
        chk(dtack_n == 1 && irq_n == 1, "R1 after release", {dtack_n, irq_n}, 2'b11);

        // R2 R7: direction register
        pa_in = 8'h3C;
        wr(3'd0, 16'h00F0);
        chk(pa_oe == 8'hF0, "R2 direction drives oe", pa_oe, 8'hF0);
        rd(3'd0, q);
        chk(q == 16'h00F0, "R7 direction read", q, 16'h00F0);

        // R5: mixed read
        wr(3'd1, 16'h00A5);
        chk(pa_out == 8'hA5, "R2 data drives out", pa_out, 8'hA5);
        rd(3'd1, q);
        chk(q == 16'h00AC, "R5 mixed read", q, 16'h00AC);

        // R3 R4: set and clear aliases
        wr(3'd2, 16'h000A);
        chk(pa_out == 8'hAF, "R3 set alias", pa_out, 8'hAF);
        wr(3'd3, 16'h0021);
        chk(pa_out == 8'h8E, "R4 clear alias", pa_out, 8'h8E);

        // R6: alias read returns pins
        rd(3'd2, q);
        chk(q == 16'h003C, "R6 set alias read", q, 16'h003C);
        rd(3'd3, q);
        chk(q == 16'h003C, "R6 clear alias read", q, 16'h003C);

        // R13: enable from bit 8, upper byte ignored elsewhere
        pb_in = 8'h0F;
        wr(3'd4, 16'h0133);
        rd(3'd4, q);
        chk(q == 16'h0133, "R13 enable loaded", q, 16'h0133);
        wr(3'd5, 16'hFE55);
        chk(pb_out == 8'h55, "R13 upper byte ignored", pb_out, 8'h55);
        rd(3'd4, q);
        chk(q == 16'h0133, "R13 enable kept", q, 16'h0133);

        // R10: event edge raises interrupt
        evt_b = 1; idle(4);
        chk(irq_n == 0, "R10 edge sets irq", irq_n, 0);
        rd(3'd6, q);
        chk(q == 16'h810F, "R6 flag and enable in read", q, 16'h810F);
        chk(irq_n == 0, "R11 alias read keeps flag", irq_n, 0);
        rd(3'd5, q);
        chk(q == 16'h811D, "R5 port B mixed read", q, 16'h811D);
        chk(irq_n == 1, "R11 data read clears flag", irq_n, 1);
        idle(4);
        chk(irq_n == 1, "R10 level does not re-set", irq_n, 1);
        evt_b = 0;

        // R10: disabled flag is latched, enable later
        evt_a = 1; idle(4); evt_a = 0;
        chk(irq_n == 1, "R10 disabled flag no irq", irq_n, 1);
        wr(3'd0, 16'h01F0);
        chk(irq_n == 0, "R10 enable exposes latched flag", irq_n, 0);
        rd(3'd1, q);
        chk(irq_n == 1, "R11 clear port A", irq_n, 1);

        // R11: edge coincident with clearing read
        @(negedge clk);
        rw = 1; addr = 3'd1; cs_n = 0; ds_n = 0; evt_a = 1;
        wait_ack(1'b0, n);
        chk(n == 3, "R8 ack on third edge", n, 3);
        chk(rdata[15] == 0, "R11 read shows old flag", rdata[15], 0);
        // R9: pins change while acknowledged
        q = rdata; pa_in = 8'hC3; idle(4);
        chk(rdata == q, "R9 read held during ack", rdata, q);
        ds_n = 1; cs_n = 1;
        wait_ack(1'b1, n);
        chk(n == 3, "R8 release on third edge", n, 3);
        chk(irq_n == 0, "R11 coincident edge wins", irq_n, 0);
        evt_a = 0;
        rd(3'd1, q);
        chk(q == 16'h8183, "R9 new pins visible", q, 16'h8183);

        // R12: strobe without chip select
        @(negedge clk);
        cs_n = 1; ds_n = 0; rw = 0; addr = 3'd0; wdata = 16'h00FF;
        idle(8);
        chk(dtack_n == 1, "R12 no ack", dtack_n, 1);
        ds_n = 1; idle(4);
        chk(pa_oe == 8'hF0, "R12 no write", pa_oe, 8'hF0);
        rd(3'd0, q);
        chk(q == 16'h01F0, "R12 register unchanged", q, 16'h01F0);

        idle(4);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule